// File: doc/BRIEF.md
# Message-Chain Fitness Evaluator

This block scores one candidate setting for a half-duplex command-response bus. A candidate has two parts: a message count `x` (how many messages the commander sends in one chain) and a transmission period `y` (how often a chain is sent). The block works out two slack values. The first is the timing slack of the responding terminal, which runs with double buffers. The second is the transmission margin left at the commander. It then folds both into one scalar cost, and a search engine placed next to it tries to make that cost as small as possible.

All values are 15-bit signed fixed point with 6 fraction bits. The terminal's interrupt and receive latencies are padded by three standard deviations. The buffer-write time depends on a ceiling count of the responses written before reception ends. One restoring divider is shared by two jobs: the ceiling count, and the reciprocal of the timing slack. A result is reported with a one-cycle done strobe and is held until the next result is reported. A candidate that breaks either constraint is flagged infeasible and gets the largest possible cost, so a search can never select it as a best.

Top module: `mc_fitness_eval`

## Requirements
- R1: Every fixed-point product is formed at full width, then rounded half-up back to 6 fraction bits: (a·b + 32) shifted right by 6 with arithmetic shift. The value 1.0 is 64.
- R2: Timing slack = 2y − [x·(2·(tI+3σI) + (tP+3σP)) + 2·TH + TW].
- R3: The write count is n = ceil(num/den), where num = (x − 1.0)·tMG and den = tP + tW1·NRD. The count is 0 when num ≤ 0. Scaled to fixed point as n·1.0, it is limited to x, and it takes the value x when den ≤ 0. From it, TW = n·(tW1·NRD) + (x − n)·(tW2·NRD).
- R4: Margin slack = (1.0 − α)·y − x·tMG.
- R5: Both slack outputs and the cost output saturate to the 15-bit signed range, −16384 to 16383.
- R6: The feasible flag is 1 only when both internal slacks are > 0. Otherwise the flag is 0 and the cost is 16383.
- R7: For a feasible candidate, cost = ε·r + (1.0 − ε)·margin, where r = floor(4096 / timing slack), the reciprocal in the same format.
- R8: `done_o` is a single-cycle pulse. Counting from the clock edge that accepts start, it rises 78 edges later for a feasible candidate and 40 edges later for an infeasible one. The outputs change only at that edge.
- R9: The candidate is captured at the start edge. A start seen while an evaluation is running is ignored.
- R10: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Starts an evaluation when the block is idle |
| cand_cnt_i | input | 15 | Candidate message count x |
| cand_per_i | input | 15 | Candidate transmission period y |
| isr_mean_i | input | 15 | Mean interrupt service time tI |
| isr_dev_i | input | 15 | Standard deviation σI of the interrupt time |
| rx_mean_i | input | 15 | Mean receive processing time tP |
| rx_dev_i | input | 15 | Standard deviation σP of the receive time |
| hipri_i | input | 15 | High-priority task time TH |
| msg_gap_i | input | 15 | Time assigned per message tMG |
| wr_early_i | input | 15 | Write time per response before reception ends, tW1 |
| wr_late_i | input | 15 | Write time per response after reception ends, tW2 |
| resp_cnt_i | input | 15 | Responses written per message, NRD |
| alpha_i | input | 15 | Margin fraction α |
| eps_i | input | 15 | Weight ε |
| slack_time_o | output | 15 | Saturated timing slack |
| slack_margin_o | output | 15 | Saturated margin slack |
| feasible_o | output | 1 | Both constraints met |
| cost_o | output | 15 | Cost to be minimised |
| done_o | output | 1 | One-cycle result strobe |

## Verification
On every cycle, the assertions check these properties:
- the done pulse lasts one cycle, and the outputs move only with it;
- an infeasible result always carries the maximum cost, and a feasible result always carries positive slacks;
- the held candidate stays frozen while an evaluation runs;
- the write count never exceeds x;
- each divider result satisfies quotient·divisor + remainder = dividend, with the remainder below the divisor.

Other behaviours can only be shown by the bench's scenarios, with values from its own reference model. These are:
- the exact rounded values of the slacks and the cost;
- the ceiling, clamp and zero-denominator cases of the write count;
- saturation;
- the two different latencies;
- a start that is ignored while busy.

// File: rtl/mc_fit_pkg.sv
package mc_fit_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CNT,
    ST_CNTW,
    ST_EVAL,
    ST_RCP,
    ST_RCPW,
    ST_DONE
  } ev_state_e;
endpackage

// File: rtl/mc_restoring_div.sv
module mc_restoring_div #(
  parameter int DW = 36
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go_i,
  input  logic [DW-1:0] dividend_i,
  input  logic [DW-1:0] divisor_i,
  output logic [DW-1:0] quo_o,
  output logic          fin_o
);
  localparam int CW = $clog2(DW + 1);

  logic [DW-1:0] rem_q, rem_d, quo_q, quo_d, dsr_q, dsr_d, dvd_q, dvd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d, fin_q, fin_d;
  logic [DW:0]   trial, diff;
  logic          ge;

  // one restoring step: shift in next dividend bit, subtract if it fits
  always_comb begin
    trial = {rem_q, quo_q[DW-1]};
    diff  = trial - {1'b0, dsr_q};
    ge    = (trial >= {1'b0, dsr_q});
  end

  always_comb begin
    rem_d  = rem_q;
    quo_d  = quo_q;
    dsr_d  = dsr_q;
    dvd_d  = dvd_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    fin_d  = 1'b0;
    if (go_i) begin
      rem_d  = '0;
      quo_d  = dividend_i;
      dsr_d  = divisor_i;
      dvd_d  = dividend_i;
      cnt_d  = CW'(DW);
      busy_d = 1'b1;
    end else if (busy_q) begin
      rem_d  = ge ? diff[DW-1:0] : trial[DW-1:0];
      quo_d  = {quo_q[DW-2:0], ge};
      cnt_d  = cnt_q - CW'(1);
      busy_d = (cnt_q != CW'(1));
      fin_d  = (cnt_q == CW'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dsr_q  <= '0;
      dvd_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      fin_q  <= 1'b0;
    end else begin
      rem_q  <= rem_d;
      quo_q  <= quo_d;
      dsr_q  <= dsr_d;
      dvd_q  <= dvd_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      fin_q  <= fin_d;
    end
  end

  assign quo_o = quo_q;
  assign fin_o = fin_q;

  // R7
  div_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_q && dsr_q != '0) |->
      (((2*DW)'(quo_q) * (2*DW)'(dsr_q) + (2*DW)'(rem_q)) == (2*DW)'(dvd_q)) && (rem_q < dsr_q));
endmodule

// File: rtl/mc_slack_terms.sv
module mc_slack_terms #(
  parameter int W    = 15,
  parameter int FRAC = 6,
  parameter int IW   = 36
) (
  input  logic signed [W-1:0]  cnt_i,
  input  logic signed [W-1:0]  per_i,
  input  logic signed [W-1:0]  isr_mean_i,
  input  logic signed [W-1:0]  isr_dev_i,
  input  logic signed [W-1:0]  rx_mean_i,
  input  logic signed [W-1:0]  rx_dev_i,
  input  logic signed [W-1:0]  hipri_i,
  input  logic signed [W-1:0]  gap_i,
  input  logic signed [W-1:0]  wr_early_i,
  input  logic signed [W-1:0]  wr_late_i,
  input  logic signed [W-1:0]  resp_i,
  input  logic signed [W-1:0]  alpha_i,
  input  logic signed [IW-1:0] nw1_i,
  output logic signed [IW-1:0] num_o,
  output logic signed [IW-1:0] den_o,
  output logic signed [IW-1:0] timing_o,
  output logic signed [IW-1:0] margin_o
);
  localparam logic signed [IW-1:0]   ONE = IW'(2**FRAC);
  localparam logic signed [2*IW-1:0] RND = (2*IW)'(2**(FRAC-1));

  function automatic logic signed [IW-1:0] ext(input logic signed [W-1:0] v);
    return {{(IW-W){v[W-1]}}, v};
  endfunction

  function automatic logic signed [IW-1:0] fxmul(input logic signed [IW-1:0] a,
                                                 input logic signed [IW-1:0] b);
    logic signed [2*IW-1:0] p;
    p = a * b;
    p = p + RND;
    return p[FRAC +: IW];
  endfunction

  logic signed [IW-1:0] x, y, pad_isr, pad_rx, per_msg, wr_a, wr_b, tw, trt;

  always_comb begin
    x        = ext(cnt_i);
    y        = ext(per_i);
    pad_isr  = ext(isr_mean_i) + ext(isr_dev_i) + ext(isr_dev_i) + ext(isr_dev_i);
    pad_rx   = ext(rx_mean_i) + ext(rx_dev_i) + ext(rx_dev_i) + ext(rx_dev_i);
    per_msg  = pad_isr + pad_isr + pad_rx;
    wr_a     = fxmul(ext(wr_early_i), ext(resp_i));
    wr_b     = fxmul(ext(wr_late_i), ext(resp_i));
    num_o    = fxmul(x - ONE, ext(gap_i));
    den_o    = ext(rx_mean_i) + wr_a;
    tw       = fxmul(nw1_i, wr_a) + fxmul(x - nw1_i, wr_b);
    trt      = fxmul(x, per_msg) + ext(hipri_i) + ext(hipri_i) + tw;
    timing_o = y + y - trt;
    margin_o = fxmul(ONE - ext(alpha_i), y) - fxmul(x, ext(gap_i));
  end
endmodule

// File: rtl/mc_result_pack.sv
module mc_result_pack #(
  parameter int W    = 15,
  parameter int FRAC = 6,
  parameter int IW   = 36
) (
  input  logic                 feas_i,
  input  logic signed [IW-1:0] rcp_i,
  input  logic signed [IW-1:0] timing_i,
  input  logic signed [IW-1:0] margin_i,
  input  logic signed [W-1:0]  eps_i,
  output logic signed [W-1:0]  slack_time_o,
  output logic signed [W-1:0]  slack_margin_o,
  output logic signed [W-1:0]  cost_o
);
  localparam logic signed [IW-1:0]   ONE  = IW'(2**FRAC);
  localparam logic signed [2*IW-1:0] RND  = (2*IW)'(2**(FRAC-1));
  localparam logic signed [IW-1:0]   MAXV = IW'(2**(W-1) - 1);
  localparam logic signed [IW-1:0]   MINV = -IW'(2**(W-1));

  function automatic logic signed [IW-1:0] fxmul(input logic signed [IW-1:0] a,
                                                 input logic signed [IW-1:0] b);
    logic signed [2*IW-1:0] p;
    p = a * b;
    p = p + RND;
    return p[FRAC +: IW];
  endfunction

  function automatic logic signed [W-1:0] sat(input logic signed [IW-1:0] v);
    logic signed [IW-1:0] c;
    c = (v > MAXV) ? MAXV : ((v < MINV) ? MINV : v);
    return c[W-1:0];
  endfunction

  logic signed [IW-1:0] eps_x, mix;

  always_comb begin
    eps_x          = {{(IW-W){eps_i[W-1]}}, eps_i};
    mix            = fxmul(eps_x, rcp_i) + fxmul(ONE - eps_x, margin_i);
    slack_time_o   = sat(timing_i);
    slack_margin_o = sat(margin_i);
    cost_o         = feas_i ? sat(mix) : MAXV[W-1:0];
  end
endmodule

// File: rtl/mc_fitness_eval.sv
module mc_fitness_eval
  import mc_fit_pkg::*;
#(
  parameter int W    = 15,
  parameter int FRAC = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic signed [W-1:0] cand_cnt_i,
  input  logic signed [W-1:0] cand_per_i,
  input  logic signed [W-1:0] isr_mean_i,
  input  logic signed [W-1:0] isr_dev_i,
  input  logic signed [W-1:0] rx_mean_i,
  input  logic signed [W-1:0] rx_dev_i,
  input  logic signed [W-1:0] hipri_i,
  input  logic signed [W-1:0] msg_gap_i,
  input  logic signed [W-1:0] wr_early_i,
  input  logic signed [W-1:0] wr_late_i,
  input  logic signed [W-1:0] resp_cnt_i,
  input  logic signed [W-1:0] alpha_i,
  input  logic signed [W-1:0] eps_i,
  output logic signed [W-1:0] slack_time_o,
  output logic signed [W-1:0] slack_margin_o,
  output logic                feasible_o,
  output logic signed [W-1:0] cost_o,
  output logic                done_o
);
  localparam int IW = 2*W + 6;
  localparam int DW = IW;
  localparam logic [DW-1:0] RECIP_NUM = DW'(2**(2*FRAC));
  localparam logic signed [W-1:0] MAXW = W'(2**(W-1) - 1);

  // reset: asserted asynchronously, released on the clock
  logic rs1_q, rs2_q, rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_i = rs2_q;

  ev_state_e state_q, state_d;
  logic signed [W-1:0]  x_q, y_q;
  logic signed [IW-1:0] nw1_q, nw1_d, tim_q, mar_q, x_ext;
  logic [IW-2:0]        rcp_q;
  logic signed [IW-1:0] num_w, den_w, timing_w, margin_w;
  logic                 cap_en, nw1_en, slk_en, rcp_en, out_en, done_d, feas_now;
  logic                 div_go, div_fin;
  logic [DW-1:0]        div_dvd, div_dsr, div_quo;
  logic signed [IW-1:0] qs;
  logic                 q_big;
  logic signed [W-1:0]  st_w, sm_w, cost_w;
  logic signed [W-1:0]  st_q, sm_q, cost_q;
  logic                 feas_q, done_q;

  assign x_ext = {{(IW-W){x_q[W-1]}}, x_q};

  mc_slack_terms #(.W(W), .FRAC(FRAC), .IW(IW)) u_terms (
    .cnt_i(x_q), .per_i(y_q),
    .isr_mean_i(isr_mean_i), .isr_dev_i(isr_dev_i),
    .rx_mean_i(rx_mean_i), .rx_dev_i(rx_dev_i),
    .hipri_i(hipri_i), .gap_i(msg_gap_i),
    .wr_early_i(wr_early_i), .wr_late_i(wr_late_i),
    .resp_i(resp_cnt_i), .alpha_i(alpha_i),
    .nw1_i(nw1_q),
    .num_o(num_w), .den_o(den_w), .timing_o(timing_w), .margin_o(margin_w)
  );

  // shared divider: ceiling count first, reciprocal second
  always_comb begin
    div_go  = (state_q == ST_CNT) || (state_q == ST_RCP);
    if (state_q == ST_CNT) begin
      div_dvd = (num_w > 0 && den_w > 0) ? (num_w + den_w - IW'(1)) : '0;
      div_dsr = (den_w > 0) ? den_w : DW'(1);
    end else begin
      div_dvd = RECIP_NUM;
      div_dsr = (tim_q > 0) ? tim_q : DW'(1);
    end
  end

  mc_restoring_div #(.DW(DW)) u_div (
    .clk(clk), .rst_n(rst_i), .go_i(div_go),
    .dividend_i(div_dvd), .divisor_i(div_dsr),
    .quo_o(div_quo), .fin_o(div_fin)
  );

  // write count: scale, then limit to the message count
  always_comb begin
    q_big = |div_quo[DW-1:W];
    qs    = {div_quo[IW-FRAC-1:0], {FRAC{1'b0}}};
    nw1_d = (den_w <= 0 || q_big || qs > x_ext) ? x_ext : qs;
  end

  assign feas_now = (tim_q > 0) && (mar_q > 0);

  mc_result_pack #(.W(W), .FRAC(FRAC), .IW(IW)) u_pack (
    .feas_i(feas_now), .rcp_i({1'b0, rcp_q}),
    .timing_i(tim_q), .margin_i(mar_q), .eps_i(eps_i),
    .slack_time_o(st_w), .slack_margin_o(sm_w), .cost_o(cost_w)
  );

  always_comb begin
    state_d = state_q;
    cap_en  = 1'b0;
    nw1_en  = 1'b0;
    slk_en  = 1'b0;
    rcp_en  = 1'b0;
    out_en  = 1'b0;
    done_d  = 1'b0;
    case (state_q)
      ST_IDLE: if (start_i) begin cap_en = 1'b1; state_d = ST_CNT; end
      ST_CNT:  state_d = ST_CNTW;
      ST_CNTW: if (div_fin) begin nw1_en = 1'b1; state_d = ST_EVAL; end
      ST_EVAL: begin
        slk_en  = 1'b1;
        state_d = (timing_w > 0 && margin_w > 0) ? ST_RCP : ST_DONE;
      end
      ST_RCP:  state_d = ST_RCPW;
      ST_RCPW: if (div_fin) begin rcp_en = 1'b1; state_d = ST_DONE; end
      ST_DONE: begin out_en = 1'b1; done_d = 1'b1; state_d = ST_IDLE; end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      state_q <= ST_IDLE;
      x_q     <= '0;
      y_q     <= '0;
      nw1_q   <= '0;
      tim_q   <= '0;
      mar_q   <= '0;
      rcp_q   <= '0;
      st_q    <= '0;
      sm_q    <= '0;
      cost_q  <= '0;
      feas_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (cap_en) begin
        x_q <= cand_cnt_i;
        y_q <= cand_per_i;
      end
      if (nw1_en) nw1_q <= nw1_d;
      if (slk_en) begin
        tim_q <= timing_w;
        mar_q <= margin_w;
      end
      if (rcp_en) rcp_q <= div_quo[IW-2:0];
      if (out_en) begin
        st_q   <= st_w;
        sm_q   <= sm_w;
        cost_q <= cost_w;
        feas_q <= feas_now;
      end
    end
  end

  assign slack_time_o   = st_q;
  assign slack_margin_o = sm_q;
  assign cost_o         = cost_q;
  assign feasible_o     = feas_q;
  assign done_o         = done_q;

  // R6
  infeas_cost_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (done_q && !feas_q) |-> (cost_q == MAXW));
  // R6
  feas_sign_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (done_q && feas_q) |-> (st_q > 0 && sm_q > 0));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_i)
    done_q |=> !done_q);
  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_i)
    !$stable(cost_q) |-> done_q);
  // R9
  cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (state_q != ST_IDLE) |=> ($stable(x_q) && $stable(y_q)));
  // R3
  nw1_bound_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (state_q == ST_EVAL) |-> (nw1_q <= x_ext));
endmodule

// File: tb/tb_mc_fitness_eval.sv
module tb_mc_fitness_eval;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic signed [14:0] cx = '0, cy = '0, ti = '0, si = '0, tp = '0, sp = '0;
  logic signed [14:0] th = '0, gap = '0, w1 = '0, w2 = '0, nrd = '0, alp = '0, eps = '0;
  logic signed [14:0] o_st, o_sm, o_cost;
  logic o_feas, o_done;

  always #4 clk = ~clk;

  mc_fitness_eval dut (
    .clk(clk), .rst_n(rst_n), .start_i(start),
    .cand_cnt_i(cx), .cand_per_i(cy),
    .isr_mean_i(ti), .isr_dev_i(si), .rx_mean_i(tp), .rx_dev_i(sp),
    .hipri_i(th), .msg_gap_i(gap), .wr_early_i(w1), .wr_late_i(w2),
    .resp_cnt_i(nrd), .alpha_i(alp), .eps_i(eps),
    .slack_time_o(o_st), .slack_margin_o(o_sm), .feasible_o(o_feas),
    .cost_o(o_cost), .done_o(o_done)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;
  bit cmp_en = 1'b0;

  // reference model state
  longint m_st = 0, m_sm = 0, m_cost = 0;
  bit     m_feas = 1'b0, m_done = 1'b0;
  longint p_st = 0, p_sm = 0, p_cost = 0;
  bit     p_feas = 1'b0;
  int     m_cnt = 0;

  function automatic longint fxm(longint a, longint b);
    return (a * b + 32) >>> 6;
  endfunction

  function automatic longint satw(longint v);
    if (v > 16383) return 16383;
    if (v < -16384) return -16384;
    return v;
  endfunction

  task automatic evaluate(output longint o_t, output longint o_m, output bit o_f,
                          output longint o_c);
    longint x, y, per, a, b, num, den, q, nw, tw, trt, tim, mar;
    x   = cx;
    y   = cy;
    per = 2 * (ti + 3 * si) + (tp + 3 * sp);
    a   = fxm(w1, nrd);
    b   = fxm(w2, nrd);
    num = fxm(x - 64, gap);
    den = tp + a;
    if (den <= 0) nw = x;
    else begin
      q  = (num > 0) ? (num + den - 1) / den : 0;
      nw = (q * 64 > x) ? x : q * 64;
    end
    tw  = fxm(nw, a) + fxm(x - nw, b);
    trt = fxm(x, per) + 2 * th + tw;
    tim = 2 * y - trt;
    mar = fxm(64 - alp, y) - fxm(x, gap);
    o_f = (tim > 0) && (mar > 0);
    o_t = satw(tim);
    o_m = satw(mar);
    if (o_f) o_c = satw(fxm(eps, 4096 / tim) + fxm(64 - eps, mar));
    else o_c = 16383;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_sm = 0; m_cost = 0; m_feas = 0; m_done = 0; m_cnt = 0;
    end else begin
      m_done = 0;
      if (m_cnt > 0) begin
        m_cnt = m_cnt - 1;
        if (m_cnt == 0) begin
          m_st = p_st; m_sm = p_sm; m_cost = p_cost; m_feas = p_feas; m_done = 1;
        end
      end else if (start) begin
        evaluate(p_st, p_sm, p_feas, p_cost);
        m_cnt = p_feas ? 78 : 40;
      end
    end
  end

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: %s got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic verify(string tag);
    chk(tag, "slack_time", longint'(o_st), m_st);
    chk(tag, "slack_margin", longint'(o_sm), m_sm);
    chk(tag, "feasible", longint'(o_feas), longint'(m_feas));
    chk(tag, "cost", longint'(o_cost), m_cost);
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (cmp_en && !finished) begin
      chk("R2", "slack_time", longint'(o_st), m_st);
      chk("R4", "slack_margin", longint'(o_sm), m_sm);
      chk("R6", "feasible", longint'(o_feas), longint'(m_feas));
      chk("R7", "cost", longint'(o_cost), m_cost);
      chk("R8", "done", longint'(o_done), longint'(m_done));
    end
  end

  task automatic set_default_cfg();
    ti = 15'sd64; si = 15'sd8; tp = 15'sd128; sp = 15'sd16; th = 15'sd192;
    gap = 15'sd96; w1 = 15'sd16; w2 = 15'sd8; nrd = 15'sd128;
    alp = 15'sd16; eps = 15'sd32;
  endtask

  task automatic run(logic signed [14:0] x, logic signed [14:0] y, string tag);
    @(negedge clk);
    cx = x; cy = y; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    do @(negedge clk); while (m_cnt != 0);
    verify(tag);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      finished = 1'b1;
      $finish;
    end
  end

  initial begin
    set_default_cfg();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    cmp_en = 1'b1;
    repeat (2) @(negedge clk);
    // R10 reset values
    chk("R10", "done", longint'(o_done), 0);
    chk("R10", "cost", longint'(o_cost), 0);
    chk("R10", "feasible", longint'(o_feas), 0);
    chk("R10", "slack_time", longint'(o_st), 0);

    run(15'sd512, 15'sd3840, "R2");       // feasible, large slack
    run(15'sd512, 15'sd1760, "R7");       // feasible, reciprocal matters
    run(15'sd512, 15'sd1280, "R6");       // timing slack negative
    alp = 15'sd58;
    run(15'sd512, 15'sd3840, "R4");       // margin negative
    alp = 15'sd1;
    run(15'sd517, 15'sd1001, "R1");       // odd fractions, rounding
    alp = 15'sd16;
    gap = 15'sd1280;
    run(15'sd192, 15'sd12800, "R3");      // write count above x, limited
    gap = 15'sd96;
    tp = 15'sd0; w1 = 15'sd0;
    run(15'sd320, 15'sd2000, "R3");       // zero denominator
    tp = 15'sd128; w1 = 15'sd16;
    run(15'sd64, 15'sd1500, "R3");        // x = 1.0, numerator zero
    run(15'sd64, 15'sd16320, "R5");       // timing slack saturates
    eps = 15'sd16320;
    run(15'sd512, 15'sd1706, "R5");       // cost saturates
    eps = 15'sd0;
    run(15'sd512, 15'sd2400, "R7");       // margin only
    eps = 15'sd64;
    run(15'sd512, 15'sd2400, "R7");       // reciprocal only
    eps = 15'sd32;

    // R9: second start during evaluation must be ignored
    @(negedge clk);
    cx = 15'sd512; cy = 15'sd3000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    cx = 15'sd128; cy = 15'sd500; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    do @(negedge clk); while (m_cnt != 0);
    verify("R9");

    // R8: start held high, back-to-back evaluations
    @(negedge clk);
    cx = 15'sd384; cy = 15'sd2600; start = 1'b1;
    repeat (170) @(negedge clk);
    start = 1'b0;
    do @(negedge clk); while (m_cnt != 0);
    verify("R8");

    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule